// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit maps a 32-bit effective address onto a physical page frame through a small set of large, programmable address blocks. It holds two banks of entry pairs, one searched for instruction fetches and one for data accesses. Each pair has an upper word, which describes the effective block and who may use it, and a lower word, which gives the physical block and the access rights. A request is compared against every entry of the bank chosen by its access type, all in parallel. The lowest-numbered entry that matches decides the result, and the result is registered one cycle later.

When an entry matches, the unit returns the physical frame and a 2-bit permission code. When nothing matches, it raises a miss, which tells the surrounding logic to fall back to the hashed page path. When translation is switched off for the access type, the address passes through unchanged with full permission and no entry is consulted. Software loads the entries through a single-word write port.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset all entry words are zero, so every translated request misses until entries are written.
- R2: A request with `req_is_fetch`=1 searches only the instruction bank, and a request with `req_is_fetch`=0 searches only the data bank.
- R3: An entry can match only if address bits 31:28 equal upper-word bits 31:28 exactly.
- R4: Upper-word bits 12:2 form an 11-bit length mask that applies to address bits 27:17. Address bits 27:17 are ANDed with the inverted mask, and the result must equal upper-word bits 27:17 for a match.
- R5: An entry that matches the address counts as a hit only if upper-word bit 1 is set for a supervisor request (`req_user`=0), or upper-word bit 0 is set for a user request (`req_user`=1). Otherwise the search goes on to the other entries.
- R6: On a hit the frame is built as follows. Bits 31:28 come from lower-word bits 31:28. Bits 27:17 are (address bits 27:17 AND mask) OR lower-word bits 27:17. Bits 16:12 come from address bits 16:12. Bits 11:0 are zero.
- R7: The permission code is bit 0 = read and bit 1 = write. Lower-word bit 1 set gives 2'b11. Otherwise lower-word bit 0 set gives 2'b01. Otherwise the code is 2'b00, and the response is still a hit.
- R8: When several entries hit, the entry with the lowest index supplies the frame and the permission.
- R9: When translation is disabled for the access type (`xlate_fetch_en` for fetches, `xlate_data_en` for data), the response is a hit with frame = address with bits 11:0 cleared and permission 2'b11.
- R10: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is sampled high, and low otherwise. `rsp_hit` and `rsp_miss` are low whenever `rsp_valid` is low.
- R11: A miss drives `rsp_miss`=1, `rsp_hit`=0, frame zero and permission 2'b00.
- R12: A write with `cfg_we`=1 updates exactly one word at the next clock edge. `cfg_side_fetch`=1 selects the instruction bank, `cfg_upper`=1 selects the upper word and `cfg_idx` selects the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_side_fetch | input | 1 | Write target bank: 1 instruction, 0 data |
| cfg_upper | input | 1 | Write target word: 1 upper, 0 lower |
| cfg_idx | input | IDX_W | Write target entry index |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Effective address |
| req_is_fetch | input | 1 | Access type: 1 fetch, 0 data |
| req_user | input | 1 | Privilege: 1 user, 0 supervisor |
| xlate_fetch_en | input | 1 | Translation enable for fetches |
| xlate_data_en | input | 1 | Translation enable for data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation resolved (entry hit or bypass) |
| rsp_miss | output | 1 | No entry matched; use the page path |
| rsp_frame | output | 32 | Physical page frame, bits 11:0 zero |
| rsp_perm | output | 2 | Permission, bit 0 read, bit 1 write |

## Verification
The bench builds the unit with its default of four entries per bank. At that size, priority ties among all four slots, the full 11-bit length mask and both banks can be reached in short directed sequences. A seeded sweep then mixes access type, privilege and the two enables across addresses around the programmed blocks. Entry words are set up so that masked-bit mismatches, entries valid for only one privilege and no-permission hits all occur.

// File: rtl/blkx_pkg.sv
// Package: field positions and shared types for the block translation matcher.
// Assumes a 32-bit effective and physical address with 4 KiB pages.
package blkx_pkg;

    localparam int WORD_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int TOP_LSB  = 28;
    localparam int MID_LSB  = 17;
    localparam int MID_MSB  = 27;
    localparam int MID_W    = MID_MSB - MID_LSB + 1;
    localparam int LEN_LSB  = 2;
    localparam int LEN_MSB  = LEN_LSB + MID_W - 1;
    localparam int OFF_W    = MID_LSB - PAGE_LSB;
    localparam int SUP_BIT  = 1;
    localparam int USR_BIT  = 0;
    localparam int PROT_RD  = 0;
    localparam int PROT_RW  = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        perm_t;

    localparam perm_t PERM_NONE = 2'b00;
    localparam perm_t PERM_RD   = 2'b01;
    localparam perm_t PERM_RW   = 2'b11;

    typedef struct packed {
        logic  hit;
        logic  miss;
        word_t frame;
        perm_t perm;
    } xlate_res_t;

    // Turn the two lower-word protection bits into a permission code.
    function automatic perm_t decode_prot(input logic [1:0] pp);
        perm_t p;
        if (pp[PROT_RW])      p = PERM_RW;
        else if (pp[PROT_RD]) p = PERM_RD;
        else                  p = PERM_NONE;
        return p;
    endfunction

endpackage

// File: rtl/blkx_regbank.sv
// Module: storage for the instruction and data entry pairs.
// Each word has its own write decode. All words clear on synchronous reset.
// Assumes cfg_idx values at or above NUM_ENTRIES are simply ignored.
module blkx_regbank
    import blkx_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_side_fetch,
    input  logic                         wr_upper,
    input  logic [IDX_W-1:0]             wr_idx,
    input  word_t                        wr_data,
    output logic [NUM_ENTRIES-1:0][WORD_W-1:0] ins_up,
    output logic [NUM_ENTRIES-1:0][WORD_W-1:0] ins_lo,
    output logic [NUM_ENTRIES-1:0][WORD_W-1:0] dat_up,
    output logic [NUM_ENTRIES-1:0][WORD_W-1:0] dat_lo
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        // Instruction-bank upper word.
        always_ff @(posedge clk) begin
            if (!rst_n)                           ins_up[e] <= '0;
            else if (sel && wr_side_fetch && wr_upper)  ins_up[e] <= wr_data;
        end

        // Instruction-bank lower word.
        always_ff @(posedge clk) begin
            if (!rst_n)                           ins_lo[e] <= '0;
            else if (sel && wr_side_fetch && !wr_upper) ins_lo[e] <= wr_data;
        end

        // Data-bank upper word.
        always_ff @(posedge clk) begin
            if (!rst_n)                            dat_up[e] <= '0;
            else if (sel && !wr_side_fetch && wr_upper)  dat_up[e] <= wr_data;
        end

        // Data-bank lower word.
        always_ff @(posedge clk) begin
            if (!rst_n)                             dat_lo[e] <= '0;
            else if (sel && !wr_side_fetch && !wr_upper) dat_lo[e] <= wr_data;
        end
    end

endmodule

// File: rtl/blkx_entry_match.sv
// Module: compares one address against one entry pair and builds its frame.
// Purely combinational. Assumes the caller has already picked the bank.
module blkx_entry_match
    import blkx_pkg::*;
(
    input  word_t upper,
    input  word_t lower,
    input  word_t addr,
    input  logic  is_user,
    output logic  hit,
    output word_t frame,
    output perm_t perm
);

    logic [MID_W-1:0] len_mask;
    logic             top_ok;
    logic             mid_ok;
    logic             priv_ok;

    // Address compare: exact top nibble, masked middle field, privilege gate.
    always_comb begin
        len_mask = upper[LEN_MSB:LEN_LSB];
        top_ok   = addr[WORD_W-1:TOP_LSB] == upper[WORD_W-1:TOP_LSB];
        mid_ok   = (addr[MID_MSB:MID_LSB] & ~len_mask) == upper[MID_MSB:MID_LSB];
        priv_ok  = is_user ? upper[USR_BIT] : upper[SUP_BIT];
        hit      = top_ok && mid_ok && priv_ok;
    end

    // Frame assembly and permission decode for this entry.
    always_comb begin
        frame = {lower[WORD_W-1:TOP_LSB],
                 (addr[MID_MSB:MID_LSB] & len_mask) | lower[MID_MSB:MID_LSB],
                 addr[MID_LSB-1:PAGE_LSB],
                 {PAGE_LSB{1'b0}}};
        perm  = decode_prot(lower[1:0]);
    end

endmodule

// File: rtl/blkx_first_hit.sv
// Module: picks the lowest-index hitting entry and forwards its result.
// Combinational. Assumes the frame and perm of entries that do not hit are don't-care.
module blkx_first_hit
    import blkx_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic [NUM_ENTRIES-1:0]              hit_vec,
    input  logic [NUM_ENTRIES-1:0][WORD_W-1:0]  frames,
    input  logic [NUM_ENTRIES-1:0][1:0]         perms,
    output logic                                any_hit,
    output word_t                               frame,
    output perm_t                               perm
);

    // Walk from the top index down so the lowest hitting index is written last.
    always_comb begin
        any_hit = |hit_vec;
        frame   = '0;
        perm    = PERM_NONE;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                frame = frames[i];
                perm  = perms[i];
            end
        end
    end

endmodule

// File: rtl/blk_xlate_unit.sv
// Module: top of the block translation matcher.
// It selects the bank by access type, matches all entries in parallel, applies
// the bypass when translation is off, and registers the result for one cycle.
// Assumes entry writes and requests in the same cycle see the old entry contents.
module blk_xlate_unit
    import blkx_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_side_fetch,
    input  logic              cfg_upper,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_is_fetch,
    input  logic              req_user,
    input  logic              xlate_fetch_en,
    input  logic              xlate_data_en,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [31:0]       rsp_frame,
    output logic [1:0]        rsp_perm
);

    logic [NUM_ENTRIES-1:0][WORD_W-1:0] ins_up, ins_lo, dat_up, dat_lo;
    logic [NUM_ENTRIES-1:0][WORD_W-1:0] sel_up, sel_lo;
    logic [NUM_ENTRIES-1:0]             hit_vec;
    logic [NUM_ENTRIES-1:0][WORD_W-1:0] ent_frame;
    logic [NUM_ENTRIES-1:0][1:0]        ent_perm;
    logic                               any_hit;
    word_t                              win_frame;
    perm_t                              win_perm;
    logic                               xlate_on;
    xlate_res_t                         res_d;
    xlate_res_t                         res_q;
    logic                               valid_q;

    blkx_regbank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (cfg_we),
        .wr_side_fetch (cfg_side_fetch),
        .wr_upper      (cfg_upper),
        .wr_idx        (cfg_idx),
        .wr_data       (cfg_wdata),
        .ins_up        (ins_up),
        .ins_lo        (ins_lo),
        .dat_up        (dat_up),
        .dat_lo        (dat_lo)
    );

    // Bank select: fetches use the instruction bank, all else the data bank.
    always_comb begin
        sel_up = req_is_fetch ? ins_up : dat_up;
        sel_lo = req_is_fetch ? ins_lo : dat_lo;
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        blkx_entry_match u_match (
            .upper   (sel_up[e]),
            .lower   (sel_lo[e]),
            .addr    (req_addr),
            .is_user (req_user),
            .hit     (hit_vec[e]),
            .frame   (ent_frame[e]),
            .perm    (ent_perm[e])
        );
    end

    blkx_first_hit #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_pick (
        .hit_vec (hit_vec),
        .frames  (ent_frame),
        .perms   (ent_perm),
        .any_hit (any_hit),
        .frame   (win_frame),
        .perm    (win_perm)
    );

    // Result mux: bypass, winning entry, or miss.
    always_comb begin
        xlate_on = req_is_fetch ? xlate_fetch_en : xlate_data_en;
        if (!xlate_on) begin
            res_d.hit   = 1'b1;
            res_d.miss  = 1'b0;
            res_d.frame = {req_addr[WORD_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
            res_d.perm  = PERM_RW;
        end else if (any_hit) begin
            res_d.hit   = 1'b1;
            res_d.miss  = 1'b0;
            res_d.frame = win_frame;
            res_d.perm  = win_perm;
        end else begin
            res_d.hit   = 1'b0;
            res_d.miss  = 1'b1;
            res_d.frame = '0;
            res_d.perm  = PERM_NONE;
        end
    end

    // Response register: captures on a request, quiets the flags otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else if (req_valid) begin
            valid_q <= 1'b1;
            res_q   <= res_d;
        end else begin
            valid_q    <= 1'b0;
            res_q.hit  <= 1'b0;
            res_q.miss <= 1'b0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_hit   = res_q.hit;
    assign rsp_miss  = res_q.miss;
    assign rsp_frame = res_q.frame;
    assign rsp_perm  = res_q.perm;

endmodule

// File: rtl/blkx_checker.sv
// Module: protocol and result-shape properties for blk_xlate_unit.
// Bound to every instance of the top. Observes ports only.
module blkx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_is_fetch,
    input logic        xlate_fetch_en,
    input logic        xlate_data_en,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic [31:0] rsp_frame,
    input logic [1:0]  rsp_perm
);

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_quiet_after_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_flags_low_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    assert_miss_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_frame == 32'h0 && rsp_perm == 2'b00));

    assert_frame_page_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_frame[11:0] == 12'h000));

    assert_perm_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_perm != 2'b10));

    assert_bypass_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_is_fetch ? xlate_fetch_en : xlate_data_en)) |=>
        (rsp_hit && rsp_perm == 2'b11 && rsp_frame[31:12] == $past(req_addr[31:12])));

endmodule

bind blk_xlate_unit blkx_checker u_blkx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_is_fetch   (req_is_fetch),
    .xlate_fetch_en (xlate_fetch_en),
    .xlate_data_en  (xlate_data_en),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_frame      (rsp_frame),
    .rsp_perm       (rsp_perm)
);

// File: tb/blk_xlate_unit_tb.sv
// Scoreboard bench: the driver pushes expected responses, the monitor pops and compares.
module blk_xlate_unit_tb;

    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_side_fetch = 1'b0;
    logic             cfg_upper = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic             req_is_fetch = 1'b0;
    logic             req_user = 1'b0;
    logic             xlate_fetch_en = 1'b1;
    logic             xlate_data_en = 1'b1;
    logic             rsp_valid, rsp_hit, rsp_miss;
    logic [31:0]      rsp_frame;
    logic [1:0]       rsp_perm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench copy of the entry words, kept from what the bench writes.
    logic [31:0] m_up [2][N];
    logic [31:0] m_lo [2][N];

    logic [35:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    blk_xlate_unit #(.NUM_ENTRIES(N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_side_fetch (cfg_side_fetch),
        .cfg_upper      (cfg_upper),
        .cfg_idx        (cfg_idx),
        .cfg_wdata      (cfg_wdata),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_is_fetch   (req_is_fetch),
        .req_user       (req_user),
        .xlate_fetch_en (xlate_fetch_en),
        .xlate_data_en  (xlate_data_en),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_miss       (rsp_miss),
        .rsp_frame      (rsp_frame),
        .rsp_perm       (rsp_perm)
    );

    // Expected {hit, miss, frame, perm} from the requirements.
    function automatic logic [35:0] expect_of(input logic [31:0] a, input logic f, input logic u);
        logic [31:0] up, lo, fr;
        logic [10:0] len;
        logic [1:0]  pm;
        int          s;
        if (!(f ? xlate_fetch_en : xlate_data_en))
            return {1'b1, 1'b0, a[31:12], 12'h000, 2'b11};            // R9
        s = f ? 1 : 0;                                                // R2
        for (int i = 0; i < N; i++) begin                             // R8 lowest first
            up  = m_up[s][i];
            lo  = m_lo[s][i];
            len = up[12:2];
            if (a[31:28] == up[31:28] && ((a[27:17] & ~len) == up[27:17]) &&
                (u ? up[0] : up[1])) begin                            // R3 R4 R5
                fr = {lo[31:28], (a[27:17] & len) | lo[27:17], a[16:12], 12'h000}; // R6
                pm = lo[1] ? 2'b11 : (lo[0] ? 2'b01 : 2'b00);         // R7
                return {1'b1, 1'b0, fr, pm};
            end
        end
        return {1'b0, 1'b1, 32'h0, 2'b00};                            // R11
    endfunction

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual hit=%0b miss=%0b frame=%08h perm=%02b expected hit=%0b miss=%0b frame=%08h perm=%02b",
                     tag, act[35], act[34], act[33:2], act[1:0], exp[35], exp[34], exp[33:2], exp[1:0]);
        end
    endtask

    task automatic cfg_write(input bit side_f, input int idx, input bit upper, input logic [31:0] d);
        @(negedge clk);
        req_valid      = 1'b0;
        cfg_we         = 1'b1;
        cfg_side_fetch = side_f;
        cfg_idx        = IDX_W'(idx);
        cfg_upper      = upper;
        cfg_wdata      = d;
        if (upper) m_up[side_f ? 1 : 0][idx] = d;
        else       m_lo[side_f ? 1 : 0][idx] = d;
    endtask

    task automatic send(input logic [31:0] a, input bit f, input bit u, input string tag);
        @(negedge clk);
        cfg_we       = 1'b0;
        req_valid    = 1'b1;
        req_addr     = a;
        req_is_fetch = f;
        req_user     = u;
        exp_q.push_back(expect_of(a, f, u));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
    endtask

    // Monitor: compares each response against the oldest expected item.
    always @(posedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            logic [35:0] act, exp;
            string       tg;
            act = {rsp_hit, rsp_miss, rsp_frame, rsp_perm};
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", act, 36'h0);
            end else begin
                exp = exp_q.pop_front();
                tg  = tag_q.pop_front();
                check(act === exp, tg, act, exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < N; i++) begin
                m_up[s][i] = '0;
                m_lo[s][i] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R10 reset quiet",
              {rsp_hit, rsp_miss, rsp_frame, rsp_perm}, 36'h0);

        // R1: empty banks miss on both sides.
        send(32'h8000_5ABC, 1'b0, 1'b0, "R1 empty data bank");
        send(32'h0000_0000, 1'b1, 1'b1, "R1 empty fetch bank");

        // R12 / R6 / R7: data entry 0, supervisor only, read-write.
        cfg_write(1'b0, 0, 1'b1, 32'h8000_0002);
        cfg_write(1'b0, 0, 1'b0, 32'h1230_0002);
        send(32'h8000_5ABC, 1'b0, 1'b0, "R6 R12 supervisor hit entry0");
        send(32'h8000_5ABC, 1'b0, 1'b1, "R5 user blocked entry0");
        send(32'h9000_5ABC, 1'b0, 1'b0, "R3 top nibble differs");
        send(32'h8002_0000, 1'b0, 1'b0, "R4 unmasked middle bit differs");

        // R4 / R7: entry 1 with mask on bits 20:17, both privileges, read only.
        cfg_write(1'b0, 1, 1'b1, 32'hA000_003F);
        cfg_write(1'b0, 1, 1'b0, 32'h4000_0001);
        send(32'hA01A_3000, 1'b0, 1'b1, "R4 masked bits pass, R7 read only");
        send(32'hA020_0000, 1'b0, 1'b0, "R4 bit outside mask differs");

        // R8: entry 3 matches the same block for both privileges, no permission.
        cfg_write(1'b0, 3, 1'b1, 32'h8000_0003);
        cfg_write(1'b0, 3, 1'b0, 32'h7000_0000);
        send(32'h8000_1000, 1'b0, 1'b0, "R8 lowest index wins");
        send(32'h8000_1000, 1'b0, 1'b1, "R5 R8 user skips entry0, R7 no-permission hit");

        // R7: both protection bits set gives read-write.
        cfg_write(1'b0, 2, 1'b1, 32'hB000_0002);
        cfg_write(1'b0, 2, 1'b0, 32'hC000_0003);
        send(32'hB000_F000, 1'b0, 1'b0, "R7 both protection bits");

        // R2: the fetch bank is separate from the data bank.
        send(32'h8000_5ABC, 1'b1, 1'b0, "R2 fetch ignores data bank");
        cfg_write(1'b1, 0, 1'b1, 32'h8000_0002);
        cfg_write(1'b1, 0, 1'b0, 32'h2000_0001);
        send(32'h8000_5ABC, 1'b1, 1'b0, "R2 fetch bank hit");
        send(32'hB000_F000, 1'b1, 1'b0, "R2 data entry2 not used for fetch");

        // R12: overwrite only the lower word of data entry 0.
        cfg_write(1'b0, 0, 1'b0, 32'h6000_0001);
        send(32'h8000_7000, 1'b0, 1'b0, "R12 rewritten lower word");
        send(32'h8000_7000, 1'b1, 1'b0, "R12 fetch entry untouched");

        // R9: bypass per access type.
        idle();
        xlate_data_en = 1'b0;
        send(32'h1234_5678, 1'b0, 1'b1, "R9 data bypass");
        send(32'h8000_5ABC, 1'b1, 1'b0, "R9 fetch still translated");
        idle();
        xlate_data_en  = 1'b1;
        xlate_fetch_en = 1'b0;
        send(32'hFFFF_FFFF, 1'b1, 1'b1, "R9 fetch bypass");
        send(32'h9000_0000, 1'b0, 1'b0, "R9 data still translated");
        idle();
        xlate_fetch_en = 1'b1;

        // R10: a quiet cycle after the last response.
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R10 idle quiet",
              {rsp_hit, rsp_miss, rsp_frame, rsp_perm}, 36'h0);

        // Seeded sweep around the programmed blocks.
        lcg = 32'h1357_9BDF;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            logic [3:0]  top;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            case (lcg[31:30])
                2'd0: top = 4'h8;
                2'd1: top = 4'hA;
                2'd2: top = 4'hB;
                default: top = lcg[27:24];
            endcase
            a = {top, (lcg[5] ? 7'h00 : lcg[22:16]), lcg[20:0]};
            if (lcg[9:6] == 4'h0) begin
                idle();
                xlate_data_en  = lcg[10];
                xlate_fetch_en = lcg[11];
            end
            send(a, lcg[3], lcg[4], "R2 R4 R5 R8 sweep");
        end
        idle();
        xlate_data_en  = 1'b1;
        xlate_fetch_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R10 all responses seen",
              36'(exp_q.size()), 36'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule